// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a bus-mapped watchdog that counts two timeout windows one after the other. A prescaler divides the bus clock into base ticks of 2^(TICK_LOG2 + prescale) cycles, where the prescale field picks a factor of 1, 2, 4 or 8. The first window lasts a programmable number of ticks. When it ends, the block latches a status flag and raises an interrupt, which acts as an early warning. The second window then starts. When it ends, the block latches a second flag and sends a one-cycle reset request on one of three outputs, chosen by a mode field.

Software keeps the system alive by writing the kick bit before the first window ends. Software may stop the timer by clearing the enable bit only while the first window is still counting. Once the early warning has fired, the reset cannot be stopped that way. The status flags are cleared by writing one to them. Reads and writes use a plain single-cycle bus: a write strobe, a byte address and write data. Read data is combinational from the address.

Top module: `dual_phase_wdt`

## Requirements
- R1: One tick lasts 2^(TICK_LOG2+P) clock cycles, where P is the control prescale field at bits 30:29.
- R2: Counting starts at the write edge that enables the timer. After (A+1) ticks, where A is the first-window field at control bits 26:22, status bit 31 sets and the interrupt rises in that same cycle.
- R3: After (B+1) further ticks, where B is the second-window field at control bits 19:15, status bit 30 sets and one reset output pulses. The mode field at control bits 1:0 selects the output: 0 selects chip, 1 selects cpu, 2 selects software, and 3 behaves like 0.
- R4: A reset pulse lasts exactly one cycle and only one output pulses. In that same edge the enable bit (control bit 31) clears, and no further reset follows.
- R5: Clearing enable during the first window freezes the count, so no interrupt and no reset occur. A later 0-to-1 change of enable restarts counting from zero.
- R6: Clearing enable during the second window does not stop it. The reset arrives at the same cycle it would have arrived with enable still set.
- R7: Writing 1 to bit 31 at offset 0x0 restarts counting from the start of the first window. This holds in either window.
- R8: Writing 1 to status bit 31 or bit 30 (offset 0x4) clears only that flag.
- R9: The interrupt output equals status bit 31 ANDed with the enable bit.
- R10: The control register sits at offset 0x8 and resets to 0x00000001. Reserved bits, offset 0x0 and unmapped offsets read as zero. The status register resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Early-warning interrupt (level) |
| rstChipOut | output | 1 | Whole-chip reset request pulse |
| rstCpuOut | output | 1 | Processor-only reset request pulse |
| rstSwOut | output | 1 | Software-visible reset request pulse |

## Verification
The bench sweeps every prescale value against several window lengths, including the shortest path (both fields 0) and the longest (both 31). It checks the cycle of the interrupt and of the reset against 2^(TICK_LOG2+P)·(A+1) and 2^(TICK_LOG2+P)·(A+B+2). A tick off by one, or a field value of 0 that gives no full tick, would shift these cycle counts.

The bench also targets three control cases:
- Enable cleared mid-first-window. A design that keeps counting would fire anyway. A design that does not clear the prescaler when enable goes back to 1 would fire early.
- Enable cleared mid-second-window. A design that obeys it would never reset.
- A kick during the second window. A design that ignores it would reset at the original time.

Last, the bench confirms each clear-on-one status write touches only its own flag. It also confirms that mode 3 lands on the chip output.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  localparam int PHASE_W = 5;
  localparam int PRE_W   = 2;

  typedef struct packed {
    logic clear;  // zero prescaler and tick counter
    logic run;    // advance the count this cycle
  } dpwStrobe_t;

  typedef enum logic [1:0] {
    MODE_CHIP = 2'd0,
    MODE_CPU  = 2'd1,
    MODE_SW   = 2'd2,
    MODE_ALT  = 2'd3
  } dpwMode_e;
endpackage

// File: rtl/dpw_tick_path.sv
module dpw_tick_path
  import dpw_pkg::*;
#(
  parameter int TICK_LOG2 = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpwStrobe_t         strobe,
  input  logic [PRE_W-1:0]   prescale,
  input  logic [PHASE_W-1:0] limit,
  output logic               expire
);
  localparam int CNT_W = TICK_LOG2 + (1 << PRE_W) - 1;

  logic [CNT_W-1:0]   preCnt;
  logic [CNT_W-1:0]   termVal;
  logic [PHASE_W-1:0] tickCnt;
  logic               baseTick;
  logic               lastTick;

  always_comb begin
    termVal  = (CNT_W'(1) << (TICK_LOG2 + int'(prescale))) - CNT_W'(1);
    baseTick = strobe.run && (preCnt >= termVal);
    lastTick = (tickCnt >= limit);
    expire   = baseTick && lastTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.clear) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.run) begin
      if (baseTick) begin
        preCnt  <= '0;
        tickCnt <= lastTick ? '0 : tickCnt + 1'b1;
      end else begin
        preCnt  <= preCnt + 1'b1;
      end
    end
  end

  a_r5_frozen_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.clear) |=> ($stable(preCnt) && $stable(tickCnt)));

  a_r1_tick_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (baseTick && !strobe.clear) |=> (preCnt == '0));
endmodule

// File: rtl/dpw_reg_ctrl.sv
module dpw_reg_ctrl
  import dpw_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               expire,
  output dpwStrobe_t         strobe,
  output logic [PRE_W-1:0]   prescale,
  output logic [PHASE_W-1:0] limit,
  output logic               irqOut,
  output logic               rstChipOut,
  output logic               rstCpuOut,
  output logic               rstSwOut
);
  localparam logic [ADDR_W-1:0] OFS_KICK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(8);

  logic               enReg;
  logic [PRE_W-1:0]   preReg;
  logic [PHASE_W-1:0] firstLen;
  logic [PHASE_W-1:0] secondLen;
  dpwMode_e           modeReg;
  logic               stsOne;
  logic               stsTwo;
  logic               phaseTwo;

  logic wrCtrl, wrSts, kickHit, enableRise, restart, endOne, endTwo, rstAny;
  logic unusedWdata;

  assign unusedWdata = ^{busWdata[28:27], busWdata[21:20], busWdata[14:2]};

  always_comb begin
    wrCtrl     = busWr && (busAddr == OFS_CTRL);
    wrSts      = busWr && (busAddr == OFS_STS);
    kickHit    = busWr && (busAddr == OFS_KICK) && busWdata[31];
    enableRise = wrCtrl && busWdata[31] && !enReg;
    restart    = kickHit || enableRise;
    endOne     = expire && !restart && !phaseTwo;
    endTwo     = expire && !restart && phaseTwo;
    strobe.clear = restart;
    strobe.run   = enReg || phaseTwo;
    prescale   = preReg;
    limit      = phaseTwo ? secondLen : firstLen;
    irqOut     = stsOne && enReg;
    rstAny     = rstChipOut || rstCpuOut || rstSwOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      preReg    <= '0;
      firstLen  <= '0;
      secondLen <= '0;
      modeReg   <= MODE_CPU;
    end else begin
      if (wrCtrl) begin
        enReg     <= busWdata[31];
        preReg    <= busWdata[30:29];
        firstLen  <= busWdata[26:22];
        secondLen <= busWdata[19:15];
        modeReg   <= dpwMode_e'(busWdata[1:0]);
      end
      if (endTwo) enReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseTwo <= 1'b0;
      stsOne   <= 1'b0;
      stsTwo   <= 1'b0;
    end else begin
      if (restart)     phaseTwo <= 1'b0;
      else if (endOne) phaseTwo <= 1'b1;
      else if (endTwo) phaseTwo <= 1'b0;

      if (endOne)                      stsOne <= 1'b1;
      else if (wrSts && busWdata[31])  stsOne <= 1'b0;

      if (endTwo)                      stsTwo <= 1'b1;
      else if (wrSts && busWdata[30])  stsTwo <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstChipOut <= 1'b0;
      rstCpuOut  <= 1'b0;
      rstSwOut   <= 1'b0;
    end else begin
      rstChipOut <= endTwo && (modeReg == MODE_CHIP || modeReg == MODE_ALT);
      rstCpuOut  <= endTwo && (modeReg == MODE_CPU);
      rstSwOut   <= endTwo && (modeReg == MODE_SW);
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == OFS_STS) begin
      busRdata[31] = stsOne;
      busRdata[30] = stsTwo;
    end else if (busAddr == OFS_CTRL) begin
      busRdata[31]    = enReg;
      busRdata[30:29] = preReg;
      busRdata[26:22] = firstLen;
      busRdata[19:15] = secondLen;
      busRdata[1:0]   = modeReg;
    end
  end

  a_r4_single_output: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rstChipOut, rstCpuOut, rstSwOut}));

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |=> !rstAny);

  a_r4_enable_dropped: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |-> (!enReg && stsTwo));

  a_r6_second_window_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phaseTwo && !restart && !expire) |=> phaseTwo);
endmodule

// File: rtl/dual_phase_wdt.sv
module dual_phase_wdt
  import dpw_pkg::*;
#(
  parameter int TICK_LOG2 = 25,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              rstChipOut,
  output logic              rstCpuOut,
  output logic              rstSwOut
);
  dpwStrobe_t         strobe;
  logic [PRE_W-1:0]   prescale;
  logic [PHASE_W-1:0] limit;
  logic               expire;

  dpw_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .expire(expire),
    .strobe(strobe), .prescale(prescale), .limit(limit),
    .irqOut(irqOut), .rstChipOut(rstChipOut), .rstCpuOut(rstCpuOut),
    .rstSwOut(rstSwOut)
  );

  dpw_tick_path #(.TICK_LOG2(TICK_LOG2)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .prescale(prescale),
    .limit(limit), .expire(expire)
  );
endmodule

// File: tb/dual_phase_wdt_tb.sv
module dual_phase_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TL2 = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, rstChipOut, rstCpuOut, rstSwOut;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  dual_phase_wdt #(.TICK_LOG2(TL2), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .rstChipOut(rstChipOut), .rstCpuOut(rstCpuOut), .rstSwOut(rstSwOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mkCtrl(input logic en, input int pre, input int a,
                                         input int b, input int mode);
    return {en, 2'(pre), 2'b0, 5'(a), 2'b0, 5'(b), 13'b0, 2'(mode)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
    busAddr = '0;
  endtask

  task automatic waitUntil(input int t0, input int rel);
    while (cyc - t0 < rel) @(negedge clk);
  endtask

  task automatic watch(input int t0, input int len, output int fIrq, output int fRst,
                       output int pulses, output logic [2:0] which);
    fIrq = -1; fRst = -1; pulses = 0; which = '0;
    while (cyc - t0 < len) begin
      @(negedge clk);
      if (irqOut && fIrq < 0) fIrq = cyc - t0;
      if (rstChipOut || rstCpuOut || rstSwOut) begin
        pulses++;
        if (fRst < 0) begin
          fRst = cyc - t0;
          which = {rstChipOut, rstCpuOut, rstSwOut};
        end
      end
    end
  endtask

  task automatic runCase(input int pre, input int a, input int b, input int mode);
    int n, t0, fIrq, fRst, pulses;
    logic [2:0] which, expWhich;
    logic [31:0] d;
    n = 1 << (TL2 + pre);
    wr(4'h8, mkCtrl(1'b1, pre, a, b, mode));
    t0 = cyc;
    watch(t0, n * (a + b + 2) + 2 * n + 2, fIrq, fRst, pulses, which);
    chk($sformatf("R1 R2 irq cycle pre=%0d a=%0d", pre, a), 32'(fIrq), 32'(n * (a + 1)));
    chk($sformatf("R3 reset cycle pre=%0d a=%0d b=%0d", pre, a, b), 32'(fRst), 32'(n * (a + b + 2)));
    chk("R4 single pulse", 32'(pulses), 32'd1);
    expWhich = (mode == 1) ? 3'b010 : (mode == 2) ? 3'b001 : 3'b100;
    chk($sformatf("R3 output for mode %0d", mode), 32'(which), 32'(expWhich));
    rd(4'h8, d);
    chk("R4 enable cleared", 32'(d[31]), 32'd0);
    chk("R9 irq low with enable clear", 32'(irqOut), 32'd0);
    rd(4'h4, d);
    chk("R2 R3 status flags", d, 32'hC000_0000);
    wr(4'h4, 32'h8000_0000);
    rd(4'h4, d);
    chk("R8 clear first flag only", d, 32'h4000_0000);
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, d);
    chk("R8 clear second flag", d, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, t1, tk, tk2, fIrq, fRst, pulses, idx;
    logic [2:0] which;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state and map
    rd(4'h8, d); chk("R10 control reset value", d, 32'h0000_0001);
    rd(4'h4, d); chk("R10 status reset value", d, 32'h0);
    rd(4'h0, d); chk("R10 kick offset reads zero", d, 32'h0);
    chk("R10 outputs idle", 32'({irqOut, rstChipOut, rstCpuOut, rstSwOut}), 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); chk("R10 reserved bits zero", d, 32'hE7CF_8003);
    rd(4'hC, d); chk("R10 unmapped offset zero", d, 32'h0);
    wr(4'h8, 32'h0000_0001);

    // R1 R2 R3 R4 R8: sweep
    idx = 0;
    for (int pre = 0; pre < 4; pre++) begin
      for (int ai = 0; ai < 3; ai++) begin
        for (int bi = 0; bi < 3; bi++) begin
          runCase(pre, (ai == 0) ? 0 : (ai == 1) ? 2 : 7,
                  (bi == 0) ? 0 : (bi == 1) ? 1 : 4, idx % 4);
          idx++;
        end
      end
    end
    runCase(0, 31, 31, 3);

    // R5: disable in first window freezes; re-enable restarts from zero
    wr(4'h8, mkCtrl(1'b1, 0, 3, 0, 1));
    t0 = cyc;
    waitUntil(t0, 8);
    wr(4'h8, mkCtrl(1'b0, 0, 3, 0, 1));
    watch(cyc, 100, fIrq, fRst, pulses, which);
    chk("R5 no irq while disabled", 32'(fIrq), 32'hFFFF_FFFF);
    chk("R5 no reset while disabled", 32'(pulses), 32'd0);
    rd(4'h4, d); chk("R5 status untouched", d, 32'h0);
    wr(4'h8, mkCtrl(1'b1, 0, 3, 0, 1));
    t1 = cyc;
    watch(t1, 24, fIrq, fRst, pulses, which);
    chk("R5 restart irq cycle", 32'(fIrq), 32'd16);
    chk("R5 restart reset cycle", 32'(fRst), 32'd20);
    wr(4'h4, 32'hC000_0000);

    // R6 R9: disable in second window does not stop reset
    wr(4'h8, mkCtrl(1'b1, 0, 1, 5, 2));
    t0 = cyc;
    waitUntil(t0, 10);
    chk("R9 irq high while enabled", 32'(irqOut), 32'd1);
    wr(4'h8, mkCtrl(1'b0, 0, 1, 5, 2));
    chk("R9 irq follows enable", 32'(irqOut), 32'd0);
    rd(4'h4, d); chk("R9 flag still latched", d, 32'h8000_0000);
    watch(t0, 40, fIrq, fRst, pulses, which);
    chk("R6 reset still arrives", 32'(fRst), 32'd32);
    chk("R6 software output", 32'(which), 32'b001);
    wr(4'h4, 32'hC000_0000);

    // R7: kick in first window, then in second window
    wr(4'h8, mkCtrl(1'b1, 0, 3, 1, 0));
    t0 = cyc;
    waitUntil(t0, 9);
    wr(4'h0, 32'h8000_0000);
    tk = cyc;
    watch(tk, 17, fIrq, fRst, pulses, which);
    chk("R7 kick delays irq", 32'(fIrq), 32'd16);
    chk("R7 no reset yet", 32'(pulses), 32'd0);
    wr(4'h0, 32'h8000_0000);
    tk2 = cyc;
    watch(tk2, 30, fIrq, fRst, pulses, which);
    chk("R7 second-window kick restarts", 32'(fRst), 32'd24);
    chk("R7 one pulse", 32'(pulses), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule